// File: doc/BRIEF.md
# Run-Time Adjustable Sample Delay Line

This block delays a stream of data samples by a whole number of accepted samples. The number is chosen through an input port and may change while the stream runs. Samples are stored in a circular register file. A write pointer moves forward one slot for each accepted sample. The read slot is the write pointer minus the requested delay, wrapping naturally at the pointer width. A requested delay of zero bypasses storage and returns the current input.

A two-state controller tracks whether the stored history is long enough for the requested delay. It starts in `FILLING` after reset. It moves to `READY` once the number of samples accepted since the last reset or delay change reaches the requested delay (`FILLING -> READY`). Any change of the delay value clears the count. If the samples accepted since that change no longer cover the new delay, the controller returns to `FILLING` (`READY -> FILLING`). Otherwise it holds its state (`FILLING -> FILLING`, `READY -> READY`). The output-valid flag is high only in `READY` and only in a cycle where the delay is unchanged.

Top module: `var_delay_line`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `out_valid` is 0.
- R2: When `delay_sel` is 0, `out_data` equals `in_data` in the same cycle.
- R3: When `delay_sel` is N (1 to 2^ADDR_W-1) and `out_valid` is 1, `out_data` equals the sample accepted N accepted samples earlier.
- R4: Only cycles with `in_valid` high store a sample and move the write pointer. Idle cycles do not count toward the delay.
- R5: With the delay held at N ≥ 1 since reset, `out_valid` stays 0 until N samples have been accepted, and rises in the cycle after the N-th accepted sample. With the delay held at 0, it rises in the second cycle after reset.
- R6: In any cycle where `delay_sel` differs from its value in the previous cycle, `out_valid` is 0. After the change, the sample accepted in the change cycle and the samples after it must number at least the new delay before `out_valid` returns to 1.
- R7: Once `out_valid` is 1, it stays 1 until the delay changes or reset is asserted, however many samples pass.
- R8: The largest delay, 2^ADDR_W-1 (255 by default), returns the correct sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is present this cycle |
| in_data | input | DATA_W | Input sample |
| delay_sel | input | ADDR_W | Requested delay in accepted samples |
| out_data | output | DATA_W | Delayed sample |
| out_valid | output | 1 | Output sample is meaningful |

## Verification
The assertions assume that `delay_sel` and `in_valid` are steady around each rising clock edge. They also assume that a delay change is seen by comparing consecutive cycle values, so a delay that changes and changes back between two edges is treated as unchanged. The bench drives every input on the falling edge, and it changes the delay only as a whole value held for at least one full cycle. Its stimulus mixes long valid bursts, idle stretches and rapid delay changes, and it includes a reset in the middle of the run. All of this keeps the stimulus inside those assumptions.

// File: rtl/vdl_pkg.sv
package vdl_pkg;
    typedef enum logic {
        FILLING = 1'b0,
        READY   = 1'b1
    } fill_state_t;
endpackage

// File: rtl/vdl_wptr.sv
module vdl_wptr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] wptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (adv) begin
            wptr <= wptr + 1'b1;
        end
    end
endmodule

// File: rtl/vdl_regfile.sv
module vdl_regfile #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/vdl_fill_fsm.sv
module vdl_fill_fsm
    import vdl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] delay_sel,
    output logic              out_valid
);
    localparam logic [ADDR_W-1:0] CNT_MAX = '1;

    fill_state_t       state_q, state_d;
    logic [ADDR_W-1:0] cnt_q, cnt_d;
    logic [ADDR_W-1:0] dly_q;
    logic              dly_change;

    assign dly_change = (delay_sel != dly_q);

    always_comb begin
        if (dly_change) begin
            cnt_d = in_valid ? {{(ADDR_W-1){1'b0}}, 1'b1} : '0;
        end else if (in_valid && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILLING: begin
                if (cnt_d >= delay_sel) begin
                    state_d = READY;
                end
            end
            READY: begin
                if (dly_change && (cnt_d < delay_sel)) begin
                    state_d = FILLING;
                end
            end
            default: state_d = FILLING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILLING;
            cnt_q   <= '0;
            dly_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dly_q   <= delay_sel;
        end
    end

    always_comb begin
        out_valid = (state_q == READY) && !dly_change;
    end
endmodule

// File: rtl/var_delay_line.sv
module var_delay_line #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [ADDR_W-1:0] delay_sel,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] raddr;
    logic [DATA_W-1:0] rdata;

    vdl_wptr #(.ADDR_W(ADDR_W)) ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .wptr  (wptr)
    );

    assign raddr = wptr - delay_sel;

    vdl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk   (clk),
        .we    (in_valid),
        .waddr (wptr),
        .wdata (in_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    vdl_fill_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .delay_sel (delay_sel),
        .out_valid (out_valid)
    );

    always_comb begin
        out_data = (delay_sel == '0) ? in_data : rdata;
    end
endmodule

// File: rtl/vdl_checker.sv
module vdl_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] delay_sel,
    input logic              out_valid,
    input logic [ADDR_W-1:0] wptr
);
    always_comb begin
        if (rst_n === 1'b0) begin
            a_r1_reset_invalid: assert (!out_valid);
        end
    end

    a_r4_idle_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(wptr));

    a_r4_valid_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (wptr == $past(wptr) + 1'b1));

    a_r5_rise_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_valid) && (delay_sel != '0)) |-> $past(in_valid));

    a_r6_change_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (delay_sel == $past(delay_sel)));

    a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (out_valid || (delay_sel != $past(delay_sel))));
endmodule

bind var_delay_line vdl_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .delay_sel (delay_sel),
    .out_valid (out_valid),
    .wptr      (wptr)
);

// File: tb/var_delay_line_tb_top.sv
module var_delay_line_tb_top;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [ADDR_W-1:0] delay_sel = '0;
    logic [DATA_W-1:0] out_data;
    logic              out_valid;

    int vectors = 0;
    int fails = 0;
    int hist[$];
    int fill = 0;
    int prev_dly = 0;
    int since_rst = 0;
    bit done = 0;

    var_delay_line #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .delay_sel (delay_sel),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    always #10 clk = ~clk;

    task automatic report(input string req, input int act, input int exp);
        fails++;
        $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    endtask

    // Called at a falling edge with rst_n high: drive, settle, compare, advance model.
    task automatic do_cycle(input bit v, input int d);
        bit chg;
        bit exp_v;
        in_valid  = v;
        in_data   = 16'($urandom);
        delay_sel = 8'(d);
        #2;
        chg   = (d != prev_dly);
        exp_v = (since_rst >= 1) && !chg && (fill >= d);
        vectors++;
        if (out_valid !== exp_v) begin
            if (since_rst == 0)  report("R1", out_valid, exp_v);
            else if (chg)        report("R6", out_valid, exp_v);
            else                 report("R5/R7", out_valid, exp_v);
        end
        if (d == 0) begin
            vectors++;
            if (out_data !== in_data) report("R2", out_data, in_data);
        end else if (exp_v) begin
            vectors++;
            if (out_data !== 16'(hist[hist.size() - d]))
                report(d == 255 ? "R8" : "R3/R4", out_data, hist[hist.size() - d]);
        end
        if (chg) fill = v ? 1 : 0;
        else if (v) fill++;
        if (v) hist.push_back(int'(in_data));
        prev_dly = d;
        since_rst++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        delay_sel = '0;
        #2;
        vectors++;
        if (out_valid !== 1'b0) report("R1", out_valid, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hist.delete();
        fill = 0;
        prev_dly = 0;
        since_rst = 0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R5, R3, R4: delay 4 with gaps in the stream
        for (int i = 0; i < 80; i++) do_cycle(($urandom % 10) < 7, 4);
        // R4: idle stretch, validity and data must hold
        for (int i = 0; i < 20; i++) do_cycle(1'b0, 4);
        // R2, R6: bypass
        for (int i = 0; i < 40; i++) do_cycle(($urandom % 2) == 0, 0);
        // R8: largest delay
        for (int i = 0; i < 700; i++) do_cycle(($urandom % 10) < 9, 255);
        // R6: shorter delay after long one
        for (int i = 0; i < 30; i++) do_cycle(1'b1, 1);
        // R6: rapid delay changes
        for (int i = 0; i < 60; i++) begin
            int d = int'($urandom % 8);
            for (int k = 0; k < 3; k++) do_cycle(($urandom % 4) != 0, d);
        end
        // R7: long steady run past counter saturation
        for (int i = 0; i < 400; i++) do_cycle(1'b1, 3);
        // R1: reset in the middle of the run
        do_reset();
        for (int i = 0; i < 60; i++) do_cycle(($urandom % 3) != 0, 10);
        for (int i = 0; i < 10; i++) do_cycle(1'b1, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule